// File: doc/BRIEF.md
# 8-bit Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small 8-bit accumulator datapath. Each cycle in which `in_valid` is high, it takes the accumulator byte, a second operand byte, an operation code and the current status byte. It captures the result byte and the new status byte in output registers, and `out_valid` marks them one clock later. Holding `in_valid` low freezes both registers.

The status byte gathers five condition bits (sign, zero, parity, half-carry, carry) and carries an interrupt-enable bit through unchanged. Two bits of the byte have constant values. Each operation changes only a defined subset of the flags and copies the rest from `flags_in`. The operations cover:

- binary add and subtract, each with and without carry in;
- the three bitwise operations;
- compare;
- increment and decrement of the operand byte;
- four single-bit rotates;
- complement;
- set carry and complement carry;
- decimal adjust after a packed-BCD addition.

Top module: `acc_alu_unit`

## Requirements
- R1: Flag byte positions are: carry bit0, constant-one bit1, parity bit2, constant-zero bit3, half-carry bit4, interrupt-enable bit5, zero bit6, sign bit7. Every output flag byte has bit1=1 and bit3=0 whatever `flags_in` holds. Bit5 is always copied from `flags_in`.
- R2: Operations that update sign, zero and parity set them as follows. Sign is result bit7. Zero is 1 when the result is 0x00. Parity is 1 when the result holds an even number of one bits.
- R3: Where half-carry is updated, it is 1 exactly when the low nibble of the source byte is greater than the low nibble of the 8-bit result. The source byte is the accumulator, except for increment and decrement, where it is the operand.
- R4: ADD (code 0) gives acc+opnd. ADC (code 1) gives acc+opnd+carry. SUB (code 2) gives acc-opnd. SBB (code 3) gives acc-opnd-carry. Each result is taken modulo 256. Carry is 1 when the unsigned result lies outside 0..255. Sign, zero, parity and half-carry update as in R2 and R3.
- R5: AND (code 4), XOR (code 5) and OR (code 6) combine acc with opnd bitwise. They update sign, zero and parity, and clear both carry and half-carry.
- R6: CMP (code 7) sets every flag exactly as SUB would. The result output equals `acc_in` unchanged.
- R7: INC (code 8) produces opnd+1 and DEC (code 9) produces opnd-1, modulo 256. Both update sign, zero, parity and half-carry, and leave carry unchanged.
- R8: The rotates change only carry.
  - RLC (code 10) rotates left and copies bit7 into both bit0 and carry.
  - RRC (code 11) rotates right and copies bit0 into both bit7 and carry.
  - RAL (code 12) rotates left through carry: bit0 takes the old carry and carry takes the old bit7.
  - RAR (code 13) rotates right through carry: bit7 takes the old carry and carry takes the old bit0.
- R9: DAA (code 17) adds a correction to acc and updates sign, zero, parity and half-carry from that addition, with the accumulator as the source byte for half-carry.
  - Low correction: 0x06 is added when half-carry is set or the low nibble exceeds 9.
  - High correction: 0x60 is added when carry is set, when the high nibble exceeds 9, or when the high nibble is at least 9 and the low nibble exceeds 9.
  - Carry becomes 1 when the high correction applies and otherwise keeps its old value.
- R10: CPL (code 14) outputs the bitwise inverse of acc and changes no flag. STC (code 15) sets carry. CMC (code 16) inverts carry. STC and CMC output acc unchanged and change no other flag.
- R11: Result and flags are registered. They update on a clock edge where `in_valid` is high, and `out_valid` is `in_valid` delayed one cycle. With `in_valid` low, the outputs hold. A synchronous active-low reset gives result 0x00, flags 0x02 and `out_valid` 0.
- R12: Any other code (18 to 31) outputs acc unchanged and changes no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation request; loads the output registers |
| op_code | input | 5 | Operation select (codes in R4 to R12) |
| acc_in | input | 8 | Accumulator byte |
| opnd_in | input | 8 | Second operand byte; source for increment and decrement |
| flags_in | input | 8 | Current status byte |
| res_out | output | 8 | Registered result byte |
| flags_out | output | 8 | Registered new status byte |
| out_valid | output | 1 | High the cycle after an accepted request |

## Verification
The assertions check, on every cycle, the properties that hold whatever the operand values are:

- the constant status bits and the interrupt-enable pass-through;
- the cleared carry and half-carry after bitwise operations;
- the kept carry after increment and decrement;
- rotates touching only carry;
- complement, set-carry and compare leaving what they must leave;
- the one-cycle valid latency and the output hold when idle.

Arithmetic exactness can only be shown by the bench's sweeps against its own integer model. That includes the modulo-256 sums and differences, borrow as carry, the half-carry nibble rule and the decimal-adjust corrections, swept over every accumulator value with corner operands such as 0x00, 0xFF, 0x99 and values around the nibble boundaries.

// File: rtl/acc_alu_pkg.sv
// Package acc_alu_pkg
// Shared widths, operation codes, status-byte bit positions and flag helper
// functions for the accumulator ALU. Assumes an 8-bit data path and an
// 8-bit status byte whose layout is fixed by the bit positions below.
package acc_alu_pkg;

    localparam int DATA_W  = 8;
    localparam int NIB_W   = DATA_W / 2;
    localparam int FLAG_W  = 8;
    localparam int OPC_W   = 5;
    localparam int BCD_MAX = 9;
    // decimal correction per nibble: skips the six codes above BCD_MAX
    localparam int BCD_FIX = (1 << NIB_W) - (BCD_MAX + 1);

    // status byte bit positions
    localparam int FB_CY   = 0;
    localparam int FB_ONE  = 1;
    localparam int FB_PAR  = 2;
    localparam int FB_ZERO = 3;
    localparam int FB_HC   = 4;
    localparam int FB_IE   = 5;
    localparam int FB_ZR   = 6;
    localparam int FB_SG   = 7;

    localparam logic [FLAG_W-1:0] FLAG_RESET = FLAG_W'(1 << FB_ONE);

    typedef enum logic [OPC_W-1:0] {
        OP_ADD = 5'd0,
        OP_ADC = 5'd1,
        OP_SUB = 5'd2,
        OP_SBB = 5'd3,
        OP_AND = 5'd4,
        OP_XOR = 5'd5,
        OP_OR  = 5'd6,
        OP_CMP = 5'd7,
        OP_INC = 5'd8,
        OP_DEC = 5'd9,
        OP_RLC = 5'd10,
        OP_RRC = 5'd11,
        OP_RAL = 5'd12,
        OP_RAR = 5'd13,
        OP_CPL = 5'd14,
        OP_STC = 5'd15,
        OP_CMC = 5'd16,
        OP_DAA = 5'd17
    } alu_op_e;

    // Replace sign, zero and parity in a flag byte from a result byte.
    function automatic logic [FLAG_W-1:0] put_szp(input logic [FLAG_W-1:0] f,
                                                  input logic [DATA_W-1:0] v);
        logic [FLAG_W-1:0] o;
        o         = f;
        o[FB_SG]  = v[DATA_W-1];
        o[FB_ZR]  = (v == '0);
        o[FB_PAR] = ~^v;
        return o;
    endfunction

    // Force the two constant bits of the status byte.
    function automatic logic [FLAG_W-1:0] fix_const(input logic [FLAG_W-1:0] f);
        logic [FLAG_W-1:0] o;
        o          = f;
        o[FB_ONE]  = 1'b1;
        o[FB_ZERO] = 1'b0;
        return o;
    endfunction

endpackage

// File: rtl/acc_alu_adder.sv
// Module acc_alu_adder
// W-bit adder/subtractor with carry or borrow in. With sub=1 it forms
// x - y - cin and reports a borrow on cout, so cout is "result left the
// unsigned range" in both directions. hc compares the low nibble of x with
// the low nibble of the sum. Purely combinational.
module acc_alu_adder
    import acc_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = W / 2
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hc
);

    logic [W:0]   raw;
    logic [W-1:0] y_eff;
    logic         c_eff;

    // two's-complement add; subtraction inverts operand and carry-in
    always_comb begin
        y_eff = sub ? ~y : y;
        c_eff = sub ? ~cin : cin;
        raw   = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
    end

    assign sum  = raw[W-1:0];
    assign cout = raw[W] ^ sub;
    assign hc   = (x[NW-1:0] > raw[NW-1:0]);

endmodule

// File: rtl/acc_alu_logic_rot.sv
// Module acc_alu_logic_rot
// Bitwise operations, single-bit rotates and complement on the accumulator.
// Produces a result byte and the new carry; for operations it does not
// handle it passes the accumulator and the carry through. Combinational.
module acc_alu_logic_rot
    import acc_alu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  alu_op_e      op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cy,
    output logic [W-1:0] res,
    output logic         cy_out
);

    // select the bitwise or rotate function for the current code
    always_comb begin
        res    = a;
        cy_out = cy;
        case (op)
            OP_AND: res = a & b;
            OP_XOR: res = a ^ b;
            OP_OR:  res = a | b;
            OP_RLC: begin
                res    = {a[W-2:0], a[W-1]};
                cy_out = a[W-1];
            end
            OP_RRC: begin
                res    = {a[0], a[W-1:1]};
                cy_out = a[0];
            end
            OP_RAL: begin
                res    = {a[W-2:0], cy};
                cy_out = a[W-1];
            end
            OP_RAR: begin
                res    = {cy, a[W-1:1]};
                cy_out = a[0];
            end
            OP_CPL: res = ~a;
            default: ;
        endcase
    end

endmodule

// File: rtl/acc_alu_dec_adjust.sv
// Module acc_alu_dec_adjust
// Decimal adjust of the accumulator after a packed-BCD addition. Decides a
// low and a high nibble correction from the incoming nibbles and the old
// half-carry and carry, adds them with its own adder, and forms the new
// carry. Combinational; assumes W is two nibbles wide.
module acc_alu_dec_adjust
    import acc_alu_pkg::*;
#(
    parameter int W  = DATA_W,
    parameter int NW = W / 2
) (
    input  logic [W-1:0] a,
    input  logic         cy,
    input  logic         hc,
    output logic [W-1:0] res,
    output logic         cy_out,
    output logic         hc_out
);

    logic [NW-1:0] lo;
    logic [NW-1:0] hi;
    logic          lo_big;
    logic          fix_lo;
    logic          fix_hi;
    logic [W-1:0]  corr;
    logic          add_cy;

    // choose the nibble corrections from the digits and old flags
    always_comb begin
        lo     = a[NW-1:0];
        hi     = a[W-1:NW];
        lo_big = (lo > NW'(BCD_MAX));
        fix_lo = hc | lo_big;
        fix_hi = cy | (hi > NW'(BCD_MAX)) | ((hi >= NW'(BCD_MAX)) & lo_big);
        corr   = {(fix_hi ? NW'(BCD_FIX) : NW'(0)), (fix_lo ? NW'(BCD_FIX) : NW'(0))};
    end

    acc_alu_adder #(.W(W), .NW(NW)) u_fix_add (
        .x    (a),
        .y    (corr),
        .cin  (1'b0),
        .sub  (1'b0),
        .sum  (res),
        .cout (add_cy),
        .hc   (hc_out)
    );

    // carry is forced by the high correction and otherwise kept
    assign cy_out = cy | fix_hi | add_cy;

endmodule

// File: rtl/acc_alu_unit.sv
// Module acc_alu_unit (top)
// 8-bit accumulator ALU. A shared adder serves add, subtract, compare,
// increment and decrement. Bitwise, rotate and complement come from
// acc_alu_logic_rot, and decimal adjust from acc_alu_dec_adjust. A flag
// merge picks which status bits each operation changes; result and status
// are registered when in_valid is high. Synchronous active-low reset.
module acc_alu_unit
    import acc_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [OPC_W-1:0]  op_code,
    input  logic [DATA_W-1:0] acc_in,
    input  logic [DATA_W-1:0] opnd_in,
    input  logic [FLAG_W-1:0] flags_in,
    output logic [DATA_W-1:0] res_out,
    output logic [FLAG_W-1:0] flags_out,
    output logic              out_valid
);

    alu_op_e           op;
    logic              is_incdec;
    logic              is_sub;
    logic              use_cin;
    logic [DATA_W-1:0] add_x;
    logic [DATA_W-1:0] add_y;
    logic              add_cin;
    logic [DATA_W-1:0] add_sum;
    logic              add_cy;
    logic              add_hc;
    logic [DATA_W-1:0] lr_res;
    logic              lr_cy;
    logic [DATA_W-1:0] daa_res;
    logic              daa_cy;
    logic              daa_hc;
    logic [DATA_W-1:0] nxt_res;
    logic [FLAG_W-1:0] nxt_flg;

    assign op = alu_op_e'(op_code);

    // steer the shared adder's inputs for the current operation
    always_comb begin
        is_incdec = (op == OP_INC) || (op == OP_DEC);
        is_sub    = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP) || (op == OP_DEC);
        use_cin   = (op == OP_ADC) || (op == OP_SBB);
        add_x     = is_incdec ? opnd_in : acc_in;
        add_y     = is_incdec ? DATA_W'(1) : opnd_in;
        add_cin   = use_cin & flags_in[FB_CY];
    end

    acc_alu_adder #(.W(DATA_W), .NW(NIB_W)) u_main_add (
        .x    (add_x),
        .y    (add_y),
        .cin  (add_cin),
        .sub  (is_sub),
        .sum  (add_sum),
        .cout (add_cy),
        .hc   (add_hc)
    );

    acc_alu_logic_rot #(.W(DATA_W)) u_logic_rot (
        .op     (op),
        .a      (acc_in),
        .b      (opnd_in),
        .cy     (flags_in[FB_CY]),
        .res    (lr_res),
        .cy_out (lr_cy)
    );

    acc_alu_dec_adjust #(.W(DATA_W), .NW(NIB_W)) u_dec_adj (
        .a      (acc_in),
        .cy     (flags_in[FB_CY]),
        .hc     (flags_in[FB_HC]),
        .res    (daa_res),
        .cy_out (daa_cy),
        .hc_out (daa_hc)
    );

    // pick the result and merge the flags each operation may change
    always_comb begin
        nxt_res = acc_in;
        nxt_flg = flags_in;
        case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
                nxt_res        = (op == OP_CMP) ? acc_in : add_sum;
                nxt_flg        = put_szp(nxt_flg, add_sum);
                nxt_flg[FB_HC] = add_hc;
                nxt_flg[FB_CY] = add_cy;
            end
            OP_INC, OP_DEC: begin
                nxt_res        = add_sum;
                nxt_flg        = put_szp(nxt_flg, add_sum);
                nxt_flg[FB_HC] = add_hc;
            end
            OP_AND, OP_XOR, OP_OR: begin
                nxt_res        = lr_res;
                nxt_flg        = put_szp(nxt_flg, lr_res);
                nxt_flg[FB_HC] = 1'b0;
                nxt_flg[FB_CY] = 1'b0;
            end
            OP_RLC, OP_RRC, OP_RAL, OP_RAR: begin
                nxt_res        = lr_res;
                nxt_flg[FB_CY] = lr_cy;
            end
            OP_CPL: nxt_res = lr_res;
            OP_STC: nxt_flg[FB_CY] = 1'b1;
            OP_CMC: nxt_flg[FB_CY] = ~flags_in[FB_CY];
            OP_DAA: begin
                nxt_res        = daa_res;
                nxt_flg        = put_szp(nxt_flg, daa_res);
                nxt_flg[FB_HC] = daa_hc;
                nxt_flg[FB_CY] = daa_cy;
            end
            default: ;
        endcase
        nxt_flg = fix_const(nxt_flg);
    end

    // output registers: load on request, hold otherwise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_out   <= '0;
            flags_out <= FLAG_RESET;
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                res_out   <= nxt_res;
                flags_out <= nxt_flg;
            end
        end
    end

endmodule

// File: rtl/acc_alu_checker.sv
// Module acc_alu_checker
// Concurrent checks on acc_alu_unit, bound to every instance of it. Keeps
// its own copy of the last accepted request so that each property relates
// the registered outputs to the inputs of the previous cycle.
module acc_alu_checker
    import acc_alu_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [OPC_W-1:0]  op_code,
    input logic [DATA_W-1:0] acc_in,
    input logic [FLAG_W-1:0] flags_in,
    input logic [DATA_W-1:0] res_out,
    input logic [FLAG_W-1:0] flags_out,
    input logic              out_valid
);

    logic              prev_v;
    logic [OPC_W-1:0]  prev_op;
    logic [DATA_W-1:0] prev_acc;
    logic [FLAG_W-1:0] prev_flg;

    // capture the request that the outputs now reflect
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_v   <= 1'b0;
            prev_op  <= '0;
            prev_acc <= '0;
            prev_flg <= '0;
        end else begin
            prev_v   <= in_valid;
            prev_op  <= op_code;
            prev_acc <= acc_in;
            prev_flg <= flags_in;
        end
    end

    AST_CONST_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        flags_out[FB_ONE] == 1'b1 && flags_out[FB_ZERO] == 1'b0); // R1
    AST_IE_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        prev_v |-> flags_out[FB_IE] == prev_flg[FB_IE]); // R1
    AST_LOGIC_SZ: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_v && (prev_op == OP_AND || prev_op == OP_XOR || prev_op == OP_OR))
        |-> (flags_out[FB_SG] == res_out[DATA_W-1] && flags_out[FB_ZR] == (res_out == '0))); // R2
    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_v && (prev_op == OP_AND || prev_op == OP_XOR || prev_op == OP_OR))
        |-> (flags_out[FB_CY] == 1'b0 && flags_out[FB_HC] == 1'b0)); // R5
    AST_CMP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_v && prev_op == OP_CMP) |-> res_out == prev_acc); // R6
    AST_INCDEC_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_v && (prev_op == OP_INC || prev_op == OP_DEC))
        |-> flags_out[FB_CY] == prev_flg[FB_CY]); // R7
    AST_ROT_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_v && (prev_op == OP_RLC || prev_op == OP_RRC || prev_op == OP_RAL || prev_op == OP_RAR))
        |-> ((flags_out ^ prev_flg) & 8'hF4) == 8'h00); // R8
    AST_CPL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_v && prev_op == OP_CPL) |-> ((flags_out ^ prev_flg) & 8'hF5) == 8'h00); // R10
    AST_STC_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (prev_v && prev_op == OP_STC) |-> (flags_out[FB_CY] == 1'b1 && res_out == prev_acc)); // R10
    AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == prev_v); // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> ($stable(res_out) && $stable(flags_out))); // R11

endmodule

bind acc_alu_unit acc_alu_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .acc_in    (acc_in),
    .flags_in  (flags_in),
    .res_out   (res_out),
    .flags_out (flags_out),
    .out_valid (out_valid)
);

// File: tb/acc_alu_unit_bench.sv
// Bench acc_alu_unit_bench
// Sweeps every operation over all accumulator values with corner operands
// and flag patterns, and compares against an integer model written from
// the requirements. Also checks reset, idle hold and unassigned codes.
module acc_alu_unit_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       in_valid;
    logic [4:0] op_code;
    logic [7:0] acc_in;
    logic [7:0] opnd_in;
    logic [7:0] flags_in;
    logic [7:0] res_out;
    logic [7:0] flags_out;
    logic       out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [7:0] opnd_set [12] = '{8'h00, 8'h01, 8'h09, 8'h0A, 8'h0F, 8'h10,
                                  8'h5A, 8'h7F, 8'h80, 8'h99, 8'hF0, 8'hFF};

    always #5 clk = ~clk;

    acc_alu_unit u_acc_alu_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .op_code   (op_code),
        .acc_in    (acc_in),
        .opnd_in   (opnd_in),
        .flags_in  (flags_in),
        .res_out   (res_out),
        .flags_out (flags_out),
        .out_valid (out_valid)
    );

    // requirement tag for an operation code
    function automatic string tag(input int op);
        if (op <= 3)       return "R4";
        else if (op <= 6)  return "R5";
        else if (op == 7)  return "R6";
        else if (op <= 9)  return "R7";
        else if (op <= 13) return "R8";
        else if (op <= 16) return "R10";
        else if (op == 17) return "R9";
        else               return "R12";
    endfunction

    // sign, zero and parity from a result value (R2)
    function automatic logic [7:0] szp(input logic [7:0] f, input int r);
        logic [7:0] o;
        logic [7:0] rb;
        o    = f;
        rb   = r[7:0];
        o[7] = (r >= 128);
        o[6] = (r == 0);
        o[2] = (($countones(rb) % 2) == 0);
        return o;
    endfunction

    // integer model: returns {result, flags}
    function automatic logic [15:0] model(input int op, input int a, input int b,
                                          input logic [7:0] f);
        int r;
        int w;
        int c;
        int h;
        int lo;
        int hi;
        int corr;
        logic [7:0] nf;
        nf = f;
        r  = a;
        c  = f[0] ? 1 : 0;
        h  = f[4] ? 1 : 0;
        case (op)
            0, 1, 2, 3, 7: begin
                if (op == 0)      w = a + b;
                else if (op == 1) w = a + b + c;
                else if (op == 3) w = a - b - c;
                else              w = a - b;
                r     = (w + 256) % 256;
                nf    = szp(nf, r);
                nf[4] = ((a % 16) > (r % 16));
                nf[0] = (w < 0) || (w > 255);
                if (op == 7) r = a;
            end
            4, 5, 6: begin
                if (op == 4)      r = a & b;
                else if (op == 5) r = a ^ b;
                else              r = a | b;
                nf    = szp(nf, r);
                nf[4] = 1'b0;
                nf[0] = 1'b0;
            end
            8, 9: begin
                r     = (op == 8) ? (b + 1) % 256 : (b + 255) % 256;
                nf    = szp(nf, r);
                nf[4] = ((b % 16) > (r % 16));
            end
            10: begin r = (a * 2) % 256 + a / 128; nf[0] = (a >= 128); end
            11: begin r = a / 2 + (a % 2) * 128;   nf[0] = (a % 2 == 1); end
            12: begin r = (a * 2) % 256 + c;       nf[0] = (a >= 128); end
            13: begin r = a / 2 + c * 128;         nf[0] = (a % 2 == 1); end
            14: r = 255 - a;
            15: nf[0] = 1'b1;
            16: nf[0] = (c == 0);
            17: begin
                lo   = a % 16;
                hi   = a / 16;
                corr = 0;
                if (h == 1 || lo > 9) corr = 6;
                if (c == 1 || hi > 9 || (hi >= 9 && lo > 9)) begin
                    corr  = corr + 96;
                    nf[0] = 1'b1;
                end
                r     = (a + corr) % 256;
                nf    = szp(nf, r);
                nf[4] = (lo > (r % 16));
            end
            default: r = a;
        endcase
        nf[1] = 1'b1;
        nf[3] = 1'b0;
        return {r[7:0], nf};
    endfunction

    // drive one request at a falling edge and check it one cycle later
    task automatic run_vec(input int op, input logic [7:0] a, input logic [7:0] b,
                           input logic [7:0] f);
        logic [15:0] e;
        op_code  = op[4:0];
        acc_in   = a;
        opnd_in  = b;
        flags_in = f;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        e = model(op, int'(a), int'(b), f);
        checks++;
        if (res_out !== e[15:8] || flags_out !== e[7:0] || out_valid !== 1'b1) begin
            fails++;
            $display("FAIL %s (R1 R2 R3) op=%0d a=%02h b=%02h f=%02h: res=%02h flags=%02h valid=%0b expected res=%02h flags=%02h valid=1",
                     tag(op), op, a, b, f, res_out, flags_out, out_valid, e[15:8], e[7:0]);
        end
    endtask

    // compare outputs with fixed reset values (R11)
    task automatic check_reset(input string what);
        checks++;
        if (res_out !== 8'h00 || flags_out !== 8'h02 || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 %s: res=%02h flags=%02h valid=%0b expected res=00 flags=02 valid=0",
                     what, res_out, flags_out, out_valid);
        end
    endtask

    initial begin
        logic [7:0] f;
        logic [15:0] e;
        rst_n    = 1'b0;
        in_valid = 1'b1;
        op_code  = 5'd0;
        acc_in   = 8'h55;
        opnd_in  = 8'h22;
        flags_in = 8'hFF;
        repeat (3) @(negedge clk);
        check_reset("reset with request held high");
        rst_n = 1'b1;

        // R4 R5 R6: binary operations, all accumulators, corner operands
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int bi = 0; bi < 12; bi++) begin
                    for (int c = 0; c < 2; c++) begin
                        f    = a[7:0] ^ opnd_set[bi] ^ 8'h5A;
                        f[0] = c[0];
                        run_vec(op, a[7:0], opnd_set[bi], f);
                    end
                end
            end
        end

        // R7 R8 R9 R10 R12: unary and flag operations, all values, C/H combos
        for (int op = 8; op < 32; op++) begin
            if (op > 19 && op != 31) continue;
            for (int x = 0; x < 256; x++) begin
                for (int hc = 0; hc < 4; hc++) begin
                    f    = x[7:0] ^ 8'hA5;
                    f[0] = hc[0];
                    f[4] = hc[1];
                    run_vec(op, x[7:0], x[7:0], f);
                end
            end
        end

        // R11: idle cycles hold the last result while inputs change
        run_vec(0, 8'h12, 8'h34, 8'h20);
        e        = model(0, 'h12, 'h34, 8'h20);
        in_valid = 1'b0;
        op_code  = 5'd14;
        acc_in   = 8'hFF;
        flags_in = 8'h00;
        repeat (3) @(negedge clk);
        checks++;
        if (res_out !== e[15:8] || flags_out !== e[7:0] || out_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 idle hold: res=%02h flags=%02h valid=%0b expected res=%02h flags=%02h valid=0",
                     res_out, flags_out, out_valid, e[15:8], e[7:0]);
        end

        // R11: reset in mid-run clears the registers
        run_vec(17, 8'h9B, 8'h00, 8'h01);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset("reset after activity");
        rst_n = 1'b1;
        run_vec(3, 8'h00, 8'hFF, 8'h01);

        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failure
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            fails++;
            $display("FAIL R11 watchdog expired: cycles=190000 expected completion earlier");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule